// File: doc/BRIEF.md
# Host I/O GPIO Register Window

This block places a small window of GPIO registers in host I/O space. The window starts at a base address that the surrounding logic supplies, and the base need not be aligned. An access whose address lies in the window is decoded into one of three kinds of port.

The first kind is an index register. The second is a data port that reaches the internal register the index selects. The third is a set of direct byte ports, each tied to the data register of one GPIO bank. Writing a direct port loads that bank's output latch. Reading a direct port returns the bank's synchronised pin levels.

A range input sets the window size. With the range input low the window is 8 bytes, and only six banks have direct ports. With it high the window is 16 bytes, and three more banks gain direct ports. Read data is combinational. Writes take effect on the rising clock edge at which the write strobe is sampled high.

Top module: `gpiowin_top`

## Requirements
- R1: The window offset is `io_addr - base_addr`, taken modulo 2^ADDR_W. With `wide_range` low, `io_hit` is high exactly for offsets 0..7, whatever the strobes are.
- R2: With `wide_range` high, `io_hit` is high exactly for offsets 0..15.
- R3: Offset 0 is the index port. A write at offset 0 loads the 8-bit index. A read at offset 0 returns the index.
- R4: Offset 1 is the data port, and it accesses the register that the index selects. Index bits 7:4 hold a bank number from 0 to 8, and index bits 3:0 select the register within that bank. Select value 0 is the bank's output latch, which can be read and written. Select value 1 is the bank's synchronised pin status, which is read-only.
- R5: The index keeps its value across any number of data-port reads and writes, until offset 0 is written again.
- R6: The direct ports are mapped as follows. Offsets 2, 3, 4, 5, 6 and 7 map to banks 8, 7, 6, 5, 0 and 1 respectively. Offsets 8, 9 and 10 map to banks 2, 3 and 4, and they exist only while `wide_range` is high.
- R7: A write to a direct port loads that bank's output latch. The new value appears on `out_latch` (bank b at bits 8b+7:8b) after the clock edge at which the write strobe is sampled.
- R8: A read of a direct port returns the bank's synchronised pin status, never its output latch.
- R9: Each pin passes through two flip-flops. A pin level present at two consecutive rising edges is the level returned from the second of those edges onward.
- R10: Reads of offsets 11..15 return 00h. Reads through the data port also return 00h when the index names bank 9..15 or a select value other than 0 or 1. Writes to any of these locations, and writes to pin status, change nothing.
- R11: When the address lies outside the window, `io_hit` is low, `io_rdata` is 00h and writes change nothing. `io_rdata` is also 00h whenever `io_rd` is low.
- R12: Reset clears every output latch, the index and the pin synchronisers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W | I/O access address |
| io_wr | input | 1 | Write strobe, sampled on the rising edge |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | DATA_W | Write data |
| io_rdata | output | DATA_W | Read data, combinational, zero when there is no read hit |
| io_hit | output | 1 | Address lies inside the active window |
| base_addr | input | ADDR_W | First address of the window |
| wide_range | input | 1 | 0 selects an 8-byte window, 1 selects a 16-byte window |
| pin_in | input | 9*DATA_W | Raw pin levels, bank b at bits DATA_W*b upward |
| out_latch | output | 9*DATA_W | Output data latches, bank b at bits DATA_W*b upward |

## Verification
Faults show up quickly at the ports.

- A wrong offset-to-bank mapping loads a latch other than the one addressed. It shows on `out_latch` one cycle after the write.
- A corrupted index sends the next data-port access to the wrong place. It shows on the very next read.
- A synchroniser with the wrong depth moves the returned pin level by a cycle. A stepped pin pattern read on every cycle exposes this.

A reference model compares `io_hit`, `io_rdata` and every latch on every cycle. Any divergence is therefore reported in the cycle it first reaches a port.

// File: rtl/gpiowin_pkg.sv
package gpiowin_pkg;

   localparam int NUM_BANKS = 9;
   localparam int OFF_W     = 4;
   localparam int BANK_IDX_W = 4;

   localparam logic [3:0] SEL_LATCH = 4'd0;
   localparam logic [3:0] SEL_PINS  = 4'd1;

   typedef enum logic [2:0] {
      PORT_NONE,
      PORT_INDEX,
      PORT_DATA,
      PORT_BANK,
      PORT_RSVD
   } port_kind_e;

   typedef struct packed {
      logic                  valid;
      logic [BANK_IDX_W-1:0] bank;
   } bank_map_t;

   // Direct-port offset to bank number; the ordering is part of the behaviour.
   function automatic bank_map_t direct_bank(input logic [OFF_W-1:0] off);
      bank_map_t m;
      m.valid = 1'b1;
      case (off)
         4'd2:    m.bank = 4'd8;
         4'd3:    m.bank = 4'd7;
         4'd4:    m.bank = 4'd6;
         4'd5:    m.bank = 4'd5;
         4'd6:    m.bank = 4'd0;
         4'd7:    m.bank = 4'd1;
         4'd8:    m.bank = 4'd2;
         4'd9:    m.bank = 4'd3;
         4'd10:   m.bank = 4'd4;
         default: begin
            m.valid = 1'b0;
            m.bank  = 4'd0;
         end
      endcase
      return m;
   endfunction

endpackage

// File: rtl/gpiowin_decode.sv
module gpiowin_decode
   import gpiowin_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [ADDR_W-1:0]     io_addr,
   input  logic [ADDR_W-1:0]     base_addr,
   input  logic                  wide_range,
   output logic                  hit,
   output port_kind_e            kind,
   output logic [BANK_IDX_W-1:0] bank_sel
);

   localparam int UPPER_W = ADDR_W - OFF_W;

   logic [ADDR_W-1:0] diff;
   logic [OFF_W-1:0]  off;
   logic              upper_zero;
   bank_map_t         map;

   initial begin
      assert (ADDR_W > OFF_W) else $error("gpiowin_decode: ADDR_W must exceed %0d", OFF_W);
   end

   assign diff       = io_addr - base_addr;
   assign off        = diff[OFF_W-1:0];
   assign upper_zero = (diff[ADDR_W-1:OFF_W] == {UPPER_W{1'b0}});
   assign hit        = upper_zero && (wide_range || !off[OFF_W-1]);
   assign map        = direct_bank(off);

   always_comb begin
      kind     = PORT_NONE;
      bank_sel = '0;
      if (hit) begin
         if (off == 4'd0)      kind = PORT_INDEX;
         else if (off == 4'd1) kind = PORT_DATA;
         else if (map.valid) begin
            kind     = PORT_BANK;
            bank_sel = map.bank;
         end
         else                  kind = PORT_RSVD;
      end
   end

   // R6: the narrow window never reaches banks 2, 3 or 4
   p_narrow_banks_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PORT_BANK && !wide_range) |-> (bank_sel inside {4'd8, 4'd7, 4'd6, 4'd5, 4'd0, 4'd1}));

   // R10: reserved slots only exist in the wide window
   p_rsvd_wide_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (kind == PORT_RSVD) |-> wide_range);

endmodule

// File: rtl/gpiowin_sync.sv
module gpiowin_sync #(
   parameter int WIDTH  = 72,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   initial begin
      assert (STAGES >= 2) else $error("gpiowin_sync: STAGES must be at least 2");
      assert (WIDTH >= 1)  else $error("gpiowin_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= d;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpiowin_bankregs.sv
module gpiowin_bankregs
   import gpiowin_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  port_kind_e                  kind,
   input  logic [BANK_IDX_W-1:0]       bank_sel,
   input  logic [DATA_W-1:0]           wdata,
   input  logic [NUM_BANKS*DATA_W-1:0] pin_status,
   output logic [NUM_BANKS*DATA_W-1:0] out_latch,
   output logic [DATA_W-1:0]           rdata
);

   initial begin
      assert (DATA_W >= 8) else $error("gpiowin_bankregs: DATA_W must be at least 8");
   end

   logic [DATA_W-1:0]     latch_q  [NUM_BANKS];
   logic [DATA_W-1:0]     pins_arr [NUM_BANKS];
   logic [DATA_W-1:0]     index_q;
   logic [BANK_IDX_W-1:0] idx_bank;
   logic [3:0]            idx_sel;
   logic                  idx_bank_ok;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign pins_arr[b]                     = pin_status[b*DATA_W +: DATA_W];
      assign out_latch[b*DATA_W +: DATA_W]   = latch_q[b];
   end

   assign idx_bank    = index_q[7:4];
   assign idx_sel     = index_q[3:0];
   assign idx_bank_ok = (32'(idx_bank) < NUM_BANKS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         index_q <= '0;
         for (int b = 0; b < NUM_BANKS; b++) latch_q[b] <= '0;
      end
      else if (wr_en) begin
         case (kind)
            PORT_INDEX: index_q <= wdata;
            PORT_DATA:  if (idx_bank_ok && idx_sel == SEL_LATCH) latch_q[idx_bank] <= wdata;
            PORT_BANK:  latch_q[bank_sel] <= wdata;
            default:    ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         case (kind)
            PORT_INDEX: rdata = index_q;
            PORT_DATA: begin
               if (idx_bank_ok && idx_sel == SEL_LATCH)     rdata = latch_q[idx_bank];
               else if (idx_bank_ok && idx_sel == SEL_PINS) rdata = pins_arr[idx_bank];
            end
            PORT_BANK:  rdata = pins_arr[bank_sel];
            default:    rdata = '0;
         endcase
      end
   end

   // R5: index only moves on an index-port write
   p_index_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && kind == PORT_INDEX) |=> $stable(index_q));

   // R7: direct write lands in the addressed bank
   p_direct_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == PORT_BANK) |=> (latch_q[$past(bank_sel)] == $past(wdata)));

   // R11: no write strobe, no latch change
   p_latch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(out_latch));

endmodule

// File: rtl/gpiowin_top.sv
module gpiowin_top
   import gpiowin_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [ADDR_W-1:0]           io_addr,
   input  logic                        io_wr,
   input  logic                        io_rd,
   input  logic [DATA_W-1:0]           io_wdata,
   output logic [DATA_W-1:0]           io_rdata,
   output logic                        io_hit,
   input  logic [ADDR_W-1:0]           base_addr,
   input  logic                        wide_range,
   input  logic [NUM_BANKS*DATA_W-1:0] pin_in,
   output logic [NUM_BANKS*DATA_W-1:0] out_latch
);

   localparam int PIN_W = NUM_BANKS * DATA_W;

   port_kind_e            kind;
   logic [BANK_IDX_W-1:0] bank_sel;
   logic [PIN_W-1:0]      pin_status;
   logic                  hit;

   gpiowin_decode #(.ADDR_W(ADDR_W)) u_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_addr    (io_addr),
      .base_addr  (base_addr),
      .wide_range (wide_range),
      .hit        (hit),
      .kind       (kind),
      .bank_sel   (bank_sel)
   );

   gpiowin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_status)
   );

   gpiowin_bankregs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (io_wr && hit),
      .rd_en      (io_rd && hit),
      .kind       (kind),
      .bank_sel   (bank_sel),
      .wdata      (io_wdata),
      .pin_status (pin_status),
      .out_latch  (out_latch),
      .rdata      (io_rdata)
   );

   assign io_hit = hit;

   // R11: a miss never drives read data
   p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_hit || !io_rd) |-> (io_rdata == '0));

   // R1: a narrow window never hits at offset 8 or above
   p_narrow_span_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (io_hit && !wide_range) |-> ((io_addr - base_addr) < ADDR_W'(8)));

endmodule

// File: tb/gpiowin_top_tb_top.sv
module gpiowin_top_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int NB = 9;
   localparam int DW = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [15:0]    io_addr = '0;
   logic           io_wr = 1'b0;
   logic           io_rd = 1'b0;
   logic [7:0]     io_wdata = '0;
   logic [7:0]     io_rdata;
   logic           io_hit;
   logic [15:0]    base_addr = 16'h0300;
   logic           wide_range = 1'b0;
   logic [NB*DW-1:0] pin_in = '0;
   logic [NB*DW-1:0] out_latch;

   int compared = 0;
   int mismatched = 0;

   // reference model state
   byte unsigned   m_latch [NB];
   byte unsigned   m_index;
   logic [NB*DW-1:0] m_hist [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   gpiowin_top dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .io_addr    (io_addr),
      .io_wr      (io_wr),
      .io_rd      (io_rd),
      .io_wdata   (io_wdata),
      .io_rdata   (io_rdata),
      .io_hit     (io_hit),
      .base_addr  (base_addr),
      .wide_range (wide_range),
      .pin_in     (pin_in),
      .out_latch  (out_latch)
   );

   function automatic int map_bank(int off);
      case (off)
         2: return 8;  3: return 7;  4: return 6;  5: return 5;
         6: return 0;  7: return 1;  8: return 2;  9: return 3;
         10: return 4;
         default: return -1;
      endcase
   endfunction

   function automatic int cur_offset();
      logic [15:0] d;
      d = io_addr - base_addr;
      return int'(d);
   endfunction

   function automatic bit exp_hit();
      return cur_offset() < (wide_range ? 16 : 8);
   endfunction

   function automatic byte unsigned exp_status(int b);
      logic [NB*DW-1:0] v;
      v = (m_hist.size() == 2) ? m_hist[0] : '0;
      return v[b*DW +: DW];
   endfunction

   function automatic byte unsigned exp_rdata();
      int off, bk, sl;
      if (!io_rd || !exp_hit()) return 8'h00;
      off = cur_offset();
      if (off == 0) return m_index;
      if (off == 1) begin
         bk = m_index >> 4;
         sl = m_index & 15;
         if (bk < NB && sl == 0) return m_latch[bk];
         if (bk < NB && sl == 1) return exp_status(bk);
         return 8'h00;
      end
      bk = map_bank(off);
      if (bk >= 0) return exp_status(bk);
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_index = 8'h00;
         for (int b = 0; b < NB; b++) m_latch[b] = 8'h00;
         m_hist.delete();
      end
      else begin
         if (io_wr && exp_hit()) begin
            int off, bk, sl;
            off = cur_offset();
            if (off == 0) m_index = io_wdata;
            else if (off == 1) begin
               bk = m_index >> 4;
               sl = m_index & 15;
               if (bk < NB && sl == 0) m_latch[bk] = io_wdata;
            end
            else begin
               bk = map_bank(off);
               if (bk >= 0) m_latch[bk] = io_wdata;
            end
         end
         m_hist.push_back(pin_in);
         if (m_hist.size() > 2) void'(m_hist.pop_front());
      end
   end

   task automatic check(string tag);
      logic [NB*DW-1:0] el;
      for (int b = 0; b < NB; b++) el[b*DW +: DW] = m_latch[b];
      compared++;
      if (io_hit !== exp_hit() || io_rdata !== exp_rdata() || out_latch !== el) begin
         mismatched++;
         $display("FAIL %s: hit=%0b rdata=%02h latch=%h expected hit=%0b rdata=%02h latch=%h",
                  tag, io_hit, io_rdata, out_latch, exp_hit(), exp_rdata(), el);
      end
   endtask

   task automatic step(string tag, int off, bit wr, bit rd, byte unsigned wd);
      @(negedge clk);
      io_addr  = base_addr + 16'(off);
      io_wr    = wr;
      io_rd    = rd;
      io_wdata = wd;
      #1 check(tag);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      // R12: reset state
      for (int i = 0; i < 3; i++) step("R12", 0, 0, 1, 0);
      @(negedge clk) rst_n = 1'b1;
      step("R12", 0, 0, 1, 0);
      for (int b = 0; b < NB; b++) pin_in[b*DW +: DW] = 8'hA0 + 8'(b);
      step("R9", 6, 0, 1, 0);
      step("R9", 6, 0, 1, 0);
      step("R9", 6, 0, 1, 0);

      // R1: narrow window decode
      for (int o = 0; o < 18; o++) step("R1", o, 0, 1, 0);
      step("R11", -1, 0, 1, 0);

      // R6 / R7: narrow direct writes, R8: reads return pins
      for (int o = 2; o < 8; o++) step("R7", o, 1, 0, 8'h10 + 8'(o));
      for (int o = 2; o < 8; o++) step("R8", o, 0, 1, 0);
      step("R11", 8, 1, 1, 8'hEE);
      step("R11", 8, 0, 1, 0);

      // R2: wide window
      wide_range = 1'b1;
      for (int o = 0; o < 18; o++) step("R2", o, 0, 1, 0);
      for (int o = 8; o < 11; o++) step("R6", o, 1, 0, 8'h50 + 8'(o));
      for (int o = 8; o < 11; o++) step("R6", o, 0, 1, 0);
      for (int o = 11; o < 16; o++) step("R10", o, 1, 1, 8'hFF);
      step("R11", 16, 1, 1, 8'h77);
      step("R11", -1, 1, 1, 8'h77);

      // R3 / R4 / R5: indexed access
      step("R3", 0, 1, 0, 8'h50);
      step("R3", 0, 0, 1, 0);
      step("R4", 1, 0, 1, 0);
      step("R4", 1, 1, 0, 8'h3C);
      step("R5", 1, 0, 1, 0);
      step("R5", 1, 1, 1, 8'hC3);
      step("R5", 1, 0, 1, 0);
      step("R5", 0, 0, 1, 0);
      step("R4", 0, 1, 0, 8'h81);
      step("R4", 1, 0, 1, 0);
      step("R10", 1, 1, 0, 8'h99);
      step("R10", 1, 0, 1, 0);
      step("R10", 0, 1, 0, 8'h90);
      step("R10", 1, 1, 1, 8'h44);
      step("R10", 0, 1, 0, 8'h32);
      step("R10", 1, 1, 1, 8'h44);
      step("R11", 1, 0, 0, 0);

      // R9: pin change latency seen through a direct port
      pin_in[0 +: DW] = 8'h5A;
      step("R9", 6, 0, 1, 0);
      step("R9", 6, 0, 1, 0);
      step("R9", 6, 0, 1, 0);
      pin_in[0 +: DW] = 8'hC5;
      step("R9", 6, 0, 1, 0);
      pin_in[0 +: DW] = 8'h0F;
      step("R9", 6, 0, 1, 0);
      step("R9", 6, 0, 1, 0);
      step("R9", 6, 0, 1, 0);

      // R1: unaligned base, wrap near top of space
      base_addr = 16'h12F5;
      wide_range = 1'b0;
      for (int o = -2; o < 10; o++) step("R1", o, 0, 1, 0);
      base_addr = 16'hFFFC;
      wide_range = 1'b1;
      for (int o = 0; o < 17; o++) step("R2", o, 1, 1, 8'(o * 7));

      // mixed traffic
      base_addr = 16'h0300;
      for (int i = 0; i < 600; i++) begin
         if (i % 50 == 0) wide_range = $urandom_range(0, 1);
         if (i % 7 == 0) pin_in = {$urandom, $urandom, $urandom};
         step("R4", int'($urandom_range(0, 19)) - 2, $urandom_range(0, 1),
              $urandom_range(0, 1), 8'($urandom));
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule